// File: doc/BRIEF.md
# Pipeline Hazard Interlock Controller

This block is the stall and bubble controller of a five-stage in-order pipeline (fetch, decode with register read, execute, memory, write-back) that has no forwarding paths. Each cycle it compares the source register fields of the instruction sitting in decode against the destination of every older instruction still in execute, memory or write-back. If a match is found, it freezes the program counter and the fetch/decode register and loads a no-op into the decode/execute register. The dependent instruction therefore waits in decode until its producer has finished writing the register file.

It also handles conditional branches. A branch compares its operands in execute, so while a branch sits in decode the controller squashes the instruction fetched behind it, and fetch does not run down an unchecked path. Once the branch moves into execute, the squash drops in that same cycle and fetch resumes at whichever address the branch picks. Instruction and data memories are separate ports, so the block never stalls for a structural conflict. All outputs are combinational from the stage inputs, plus a single run flag that is cleared by reset.

Top module: `hzi_interlock`

## Requirements
- R1: `freeze_o` and `bubble_o` are both high in any cycle where a decode source field equals the destination of the execute, memory or write-back entry, provided that entry has its write-enable set and its class is ALU (0) or LOAD (1).
- R2: If no stage entry matches a decode source, or the matching entry has its write-enable low, `freeze_o` and `bubble_o` stay low.
- R3: An entry of class STORE (2) or BRANCH (3) never causes a stall, even when its write-enable is set and its destination matches.
- R4: Register 0 never creates a dependence, whatever the stage entries hold.
- R5: A consumer decoded directly behind a load of its source register is held for exactly three cycles, while the load passes through execute, memory and write-back. In the fourth cycle it is released.
- R6: While a branch is in decode with no data hazard, `squash_o` is high and `freeze_o` and `bubble_o` are low. `squash_o` is low whenever no branch is in decode.
- R7: If a branch in decode also has a data hazard, the freeze takes precedence: `freeze_o` and `bubble_o` are high and `squash_o` is low. `freeze_o` and `squash_o` are never high together.
- R8: While `rst_i` is high, and in the cycle before the first clock edge that samples it low, `freeze_o` and `bubble_o` are high and `squash_o` is low. Normal operation, with the first fetch, begins in the cycle after that edge.
- R9: Every source field is checked on its own, so a match on the second source field alone stalls just as a match on the first does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| id_src_i | input | NUM_SRC*REG_AW | Source register fields of the decode instruction; field k is bits [k*REG_AW +: REG_AW] |
| id_branch_i | input | 1 | A conditional branch is in decode |
| ex_dst_i | input | REG_AW | Destination register of the execute entry |
| ex_wen_i | input | 1 | Execute entry writes a register |
| ex_cls_i | input | 2 | Execute entry class: 0 ALU, 1 LOAD, 2 STORE, 3 BRANCH |
| mem_dst_i | input | REG_AW | Destination register of the memory entry |
| mem_wen_i | input | 1 | Memory entry writes a register |
| mem_cls_i | input | 2 | Memory entry class |
| wb_dst_i | input | REG_AW | Destination register of the write-back entry |
| wb_wen_i | input | 1 | Write-back entry writes a register |
| wb_cls_i | input | 2 | Write-back entry class |
| freeze_o | output | 1 | Hold the PC and the fetch/decode register |
| bubble_o | output | 1 | Load a no-op with write-enable cleared into decode/execute |
| squash_o | output | 1 | Discard the fetch behind an unresolved branch |

## Verification
The two functions that can land in the same cycle are the data-hazard freeze and the branch squash, because a branch in decode may read a register that is still in flight. The vector table provokes this with a branch whose operand matches a live execute destination, and expects freeze and bubble high with squash low. A second vector pairs a branch with a matching but zero-numbered destination and expects squash alone. Together these show that the precedence between the two is decided by the hazard and not by the branch flag.

// File: rtl/hzi_pkg.sv
package hzi_pkg;

   typedef enum logic [1:0] {
      CLS_ALU    = 2'd0,
      CLS_LOAD   = 2'd1,
      CLS_STORE  = 2'd2,
      CLS_BRANCH = 2'd3
   } op_cls_e;

   function automatic logic cls_writes_reg(op_cls_e c);
      return (c == CLS_ALU) || (c == CLS_LOAD);
   endfunction

endpackage

// File: rtl/hzi_stage_cmp.sv
module hzi_stage_cmp
   import hzi_pkg::*;
#(
   parameter int REG_AW         = 5,
   parameter int NUM_SRC        = 2,
   parameter bit ZERO_HARDWIRED = 1'b1
) (
   input  logic [NUM_SRC*REG_AW-1:0] src_i,
   input  logic [REG_AW-1:0]         dst_i,
   input  logic                      wen_i,
   input  op_cls_e                   cls_i,
   output logic                      hit_o
);

   logic               live_write;
   logic               dst_live;
   logic [NUM_SRC-1:0] src_eq;

   assign live_write = wen_i && cls_writes_reg(cls_i);

   generate
      if (ZERO_HARDWIRED) begin : g_zero_fixed
         assign dst_live = |dst_i;
      end else begin : g_zero_plain
         assign dst_live = 1'b1;
      end

      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
         assign src_eq[s] = (src_i[s*REG_AW +: REG_AW] == dst_i);
      end
   endgenerate

   assign hit_o = live_write && dst_live && (|src_eq);

   // R3: non-writing classes stay silent; R4: register 0 never matches
   always_comb begin
      if (cls_i == CLS_STORE || cls_i == CLS_BRANCH)
         p_nonwriter_silent_r3: assert (!hit_o);
      if (ZERO_HARDWIRED && dst_i == '0)
         p_zero_never_hits_r4: assert (!hit_o);
   end

endmodule

// File: rtl/hzi_run_gate.sv
module hzi_run_gate (
   input  logic clk_i,
   input  logic rst_i,
   output logic run_o
);

   logic run_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) run_q <= 1'b0;
      else       run_q <= 1'b1;
   end

   assign run_o = run_q;

endmodule

// File: rtl/hzi_interlock.sv
module hzi_interlock
   import hzi_pkg::*;
#(
   parameter int REG_AW         = 5,
   parameter int NUM_SRC        = 2,
   parameter bit ZERO_HARDWIRED = 1'b1
) (
   input  logic                      clk_i,
   input  logic                      rst_i,
   input  logic [NUM_SRC*REG_AW-1:0] id_src_i,
   input  logic                      id_branch_i,
   input  logic [REG_AW-1:0]         ex_dst_i,
   input  logic                      ex_wen_i,
   input  logic [1:0]                ex_cls_i,
   input  logic [REG_AW-1:0]         mem_dst_i,
   input  logic                      mem_wen_i,
   input  logic [1:0]                mem_cls_i,
   input  logic [REG_AW-1:0]         wb_dst_i,
   input  logic                      wb_wen_i,
   input  logic [1:0]                wb_cls_i,
   output logic                      freeze_o,
   output logic                      bubble_o,
   output logic                      squash_o
);

   localparam int NUM_STAGES = 3;

   generate
      if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
         $error("hzi_interlock: REG_AW must lie in 1..8");
      end
      if (NUM_SRC < 1 || NUM_SRC > 4) begin : g_bad_src
         $error("hzi_interlock: NUM_SRC must lie in 1..4");
      end
   endgenerate

   logic [REG_AW-1:0]     st_dst [NUM_STAGES];
   logic                  st_wen [NUM_STAGES];
   op_cls_e               st_cls [NUM_STAGES];
   logic [NUM_STAGES-1:0] st_hit;
   logic                  hazard;
   logic                  run;

   assign st_dst[0] = ex_dst_i;
   assign st_wen[0] = ex_wen_i;
   assign st_cls[0] = op_cls_e'(ex_cls_i);
   assign st_dst[1] = mem_dst_i;
   assign st_wen[1] = mem_wen_i;
   assign st_cls[1] = op_cls_e'(mem_cls_i);
   assign st_dst[2] = wb_dst_i;
   assign st_wen[2] = wb_wen_i;
   assign st_cls[2] = op_cls_e'(wb_cls_i);

   generate
      for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
         hzi_stage_cmp #(
            .REG_AW        (REG_AW),
            .NUM_SRC       (NUM_SRC),
            .ZERO_HARDWIRED(ZERO_HARDWIRED)
         ) u_cmp (
            .src_i (id_src_i),
            .dst_i (st_dst[g]),
            .wen_i (st_wen[g]),
            .cls_i (st_cls[g]),
            .hit_o (st_hit[g])
         );
      end
   endgenerate

   hzi_run_gate u_run (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .run_o (run)
   );

   assign hazard   = |st_hit;
   assign freeze_o = !run || hazard;
   assign bubble_o = !run || hazard;
   assign squash_o = run && id_branch_i && !hazard;

   // R1: a running freeze always has a live writer behind it
   p_freeze_has_writer_r1: assert property (@(posedge clk_i) disable iff (rst_i)
      (freeze_o && run) |-> (ex_wen_i || mem_wen_i || wb_wen_i));

   // R6: squash only with a branch in decode
   p_squash_needs_branch_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      squash_o |-> id_branch_i);

   // R7: freeze and squash exclusive
   p_freeze_squash_excl_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      !(freeze_o && squash_o));

   // R8: first cycle out of reset is still frozen
   p_reset_exit_frozen_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(rst_i) |-> (freeze_o && bubble_o && !squash_o));

endmodule

// File: tb/tb_hzi_interlock.sv
module tb_hzi_interlock;

   localparam int AW = 5;
   localparam int NV = 12;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [2*AW-1:0] id_src = '0;
   logic          id_branch = 1'b0;
   logic [AW-1:0] ex_dst = '0, mem_dst = '0, wb_dst = '0;
   logic          ex_wen = 1'b0, mem_wen = 1'b0, wb_wen = 1'b0;
   logic [1:0]    ex_cls = '0, mem_cls = '0, wb_cls = '0;
   logic          freeze, bubble, squash;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   hzi_interlock #(.REG_AW(AW), .NUM_SRC(2)) dut (
      .clk_i(clk), .rst_i(rst), .id_src_i(id_src), .id_branch_i(id_branch),
      .ex_dst_i(ex_dst), .ex_wen_i(ex_wen), .ex_cls_i(ex_cls),
      .mem_dst_i(mem_dst), .mem_wen_i(mem_wen), .mem_cls_i(mem_cls),
      .wb_dst_i(wb_dst), .wb_wen_i(wb_wen), .wb_cls_i(wb_cls),
      .freeze_o(freeze), .bubble_o(bubble), .squash_o(squash)
   );

   localparam logic [7:0] IDLE = 8'h00;

   // {src1, src0, branch, ex{dst,wen,cls}, mem{..}, wb{..}, exp{freeze,bubble,squash}}
   localparam logic [37:0] VEC [NV] = '{
      {5'd2, 5'd1, 1'b0, {5'd5,1'b1,2'd0}, {5'd6,1'b1,2'd0}, {5'd7,1'b1,2'd0}, 3'b000},
      {5'd2, 5'd1, 1'b0, {5'd1,1'b1,2'd0}, IDLE, IDLE, 3'b110},
      {5'd2, 5'd1, 1'b0, IDLE, {5'd1,1'b1,2'd1}, IDLE, 3'b110},
      {5'd2, 5'd1, 1'b0, IDLE, IDLE, {5'd1,1'b1,2'd0}, 3'b110},
      {5'd2, 5'd1, 1'b0, {5'd1,1'b0,2'd0}, IDLE, IDLE, 3'b000},
      {5'd2, 5'd1, 1'b0, {5'd1,1'b1,2'd2}, IDLE, IDLE, 3'b000},
      {5'd2, 5'd1, 1'b0, IDLE, {5'd2,1'b1,2'd3}, IDLE, 3'b000},
      {5'd0, 5'd0, 1'b0, {5'd0,1'b1,2'd0}, IDLE, IDLE, 3'b000},
      {5'd4, 5'd3, 1'b0, IDLE, IDLE, {5'd4,1'b1,2'd1}, 3'b110},
      {5'd2, 5'd1, 1'b1, IDLE, IDLE, IDLE, 3'b001},
      {5'd2, 5'd1, 1'b1, {5'd2,1'b1,2'd1}, IDLE, IDLE, 3'b110},
      {5'd0, 5'd9, 1'b1, IDLE, {5'd0,1'b1,2'd0}, IDLE, 3'b001}
   };

   function automatic string tag_of(int i);
      case (i)
         0, 4:    return "R2";
         1, 2, 3: return "R1";
         5, 6:    return "R3";
         7, 11:   return "R4";
         8:       return "R9";
         9:       return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic check(string tag, logic [2:0] exp);
      n_chk++;
      if ({freeze, bubble, squash} !== exp) begin
         n_fail++;
         $display("FAIL %s: {freeze,bubble,squash} actual %b expected %b",
                  tag, {freeze, bubble, squash}, exp);
      end
   endtask

   task automatic set_stage(int s, logic [7:0] f);
      case (s)
         0: {ex_dst, ex_wen, ex_cls}    = f;
         1: {mem_dst, mem_wen, mem_cls} = f;
         default: {wb_dst, wb_wen, wb_cls} = f;
      endcase
   endtask

   initial begin
      #(4 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R8: reset holds freeze even with a branch in decode
      id_branch = 1'b1;
      id_src    = {5'd2, 5'd1};
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R8", 3'b110);
      rst = 1'b0;
      #1 check("R8", 3'b110);
      @(negedge clk);
      check("R8", 3'b001);
      id_branch = 1'b0;

      // table walk
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         {id_src[9:5], id_src[4:0], id_branch} = VEC[i][37:27];
         set_stage(0, VEC[i][26:19]);
         set_stage(1, VEC[i][18:11]);
         set_stage(2, VEC[i][10:3]);
         #1 check(tag_of(i), VEC[i][2:0]);
      end

      // R5: load to r6 walks EX -> MEM -> WB while consumer waits in decode
      @(negedge clk);
      id_branch = 1'b0;
      id_src    = {5'd0, 5'd6};
      for (int c = 0; c < 4; c++) begin
         set_stage(0, IDLE);
         set_stage(1, IDLE);
         set_stage(2, IDLE);
         if (c < 3) set_stage(c, {5'd6, 1'b1, 2'd1});
         #1 check("R5", (c < 3) ? 3'b110 : 3'b000);
         @(negedge clk);
      end

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule